// File: doc/BRIEF.md
# Signal Monitor Serial Result Port

This block sends the latest measurement results of a signal monitor to a receiver over a single serial data line. It generates its own serial clock by dividing the core clock and raises a frame marker before each group of words. Three result words can be sent: a 20-bit power magnitude, a 13-bit peak value and a 13-bit threshold-crossing count. Each word has its own enable, and a disabled word is left out of the frame, so the frame is shorter.

A one-cycle strobe captures a new set of results into a holding stage. The next frame is built from that stage when the serial clock falls, as long as the master output enable is set and at least one word is enabled. A strobe that arrives while a frame is being sent is held for the following frame. With sleep set, the serial clock stays low whenever nothing is held or in flight. With sleep clear, the clock runs without a break and the data line idles low.

Top module: `smon_serial_port`

## Requirements
- R1: A frame carries the enabled words in the fixed order magnitude (20 bits), peak (13 bits), threshold (13 bits), each MSB first. A disabled word is skipped, and its bits take up no serial clock periods.
- R2: frame_o is high for exactly one serial clock period just before the first data bit of a frame, and sdata_o is low during that period.
- R3: div_sel_i selects the serial clock period in core clock cycles: 2'b00 or 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8, with a 50% duty cycle.
- R4: sdata_o and frame_o change only on a core clock edge where sclk_o goes from high to low, so a receiver can sample them on the rising edge of sclk_o.
- R5: No frame starts while out_en_i is low. A result captured in that time is kept and sent once out_en_i goes high.
- R6: While sleep_i is high and no result is held or being sent, sclk_o stays low.
- R7: While sleep_i is low, sclk_o toggles without a break, and sdata_o is low on every rising edge of sclk_o outside a frame.
- R8: A result strobe that arrives during a frame leaves that frame's bits unchanged, and its words are sent in the next frame.
- R9: While rst_ni is low, sclk_o, sdata_o and frame_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mag_i | input | 20 | Power magnitude result |
| peak_i | input | 13 | Peak result |
| thr_i | input | 13 | Threshold-crossing count |
| result_valid_i | input | 1 | One-cycle strobe that captures a new set of results |
| mag_en_i | input | 1 | Include the magnitude word in frames |
| peak_en_i | input | 1 | Include the peak word in frames |
| thr_en_i | input | 1 | Include the threshold word in frames |
| div_sel_i | input | 2 | Serial clock divide code |
| sleep_i | input | 1 | Park sclk_o low when nothing is held |
| out_en_i | input | 1 | Master output enable |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| frame_o | output | 1 | Frame marker |

## Verification
The assertions assume the word enables are held steady from a result strobe until the frame that carries it has finished. A change of div_sel_i is assumed to be harmless to a frame only between frames. The bench changes enables and divide codes only after the scoreboard queue is empty and its monitor is outside a frame. The one exception is the mid-frame strobe case, which sends a second strobe with the same enables while the first frame is still being shifted out.

// File: rtl/smon_sport_pkg.sv
package smon_sport_pkg;
  // core clock cycles in half a serial clock period
  function automatic logic [2:0] half_period(input logic [1:0] code);
    case (code)
      2'b10:   half_period = 3'd2;
      2'b11:   half_period = 3'd4;
      default: half_period = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/smon_sclk_gen.sv
module smon_sclk_gen
  import smon_sport_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] div_sel_i,
  input  logic       run_i,
  output logic       sclk_o,
  output logic       fall_o
);
  logic [2:0] cnt_q;
  logic       sclk_q;
  logic       wrap;

  assign wrap   = run_i && (cnt_q >= half_period(div_sel_i) - 3'd1);
  assign fall_o = wrap && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 3'd1;
    end
  end
endmodule

// File: rtl/smon_result_hold.sv
module smon_result_hold #(
  parameter int MAG_W = 20,
  parameter int PK_W  = 13,
  parameter int THR_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MAG_W-1:0] mag_i,
  input  logic [PK_W-1:0]  peak_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             valid_i,
  input  logic             take_i,
  output logic [MAG_W-1:0] mag_o,
  output logic [PK_W-1:0]  peak_o,
  output logic [THR_W-1:0] thr_o,
  output logic             pending_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_o     <= '0;
      peak_o    <= '0;
      thr_o     <= '0;
      pending_o <= 1'b0;
    end else begin
      if (valid_i) begin
        mag_o  <= mag_i;
        peak_o <= peak_i;
        thr_o  <= thr_i;
      end
      // a new strobe wins over a take in the same cycle
      if (valid_i)     pending_o <= 1'b1;
      else if (take_i) pending_o <= 1'b0;
    end
  end
endmodule

// File: rtl/smon_frame_shift.sv
module smon_frame_shift #(
  parameter int MAG_W = 20,
  parameter int PK_W  = 13,
  parameter int THR_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             pending_i,
  input  logic             out_en_i,
  input  logic [2:0]       en_i,      // {thr, peak, mag}
  input  logic [MAG_W-1:0] mag_i,
  input  logic [PK_W-1:0]  peak_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             take_o,
  output logic             busy_o,
  output logic             sdata_o,
  output logic             frame_o
);
  localparam int TOT   = MAG_W + PK_W + THR_W;
  localparam int CNT_W = $clog2(TOT + 1);

  logic [TOT-1:0]   pack, shift_q;
  logic [CNT_W-1:0] len, left_q;

  // enabled words packed MSB-aligned in order mag, peak, thr
  always_comb begin
    pack = '0;
    len  = '0;
    if (en_i[0]) begin
      pack = pack | ({mag_i, {(TOT-MAG_W){1'b0}}} >> len);
      len  = len + CNT_W'(MAG_W);
    end
    if (en_i[1]) begin
      pack = pack | ({peak_i, {(TOT-PK_W){1'b0}}} >> len);
      len  = len + CNT_W'(PK_W);
    end
    if (en_i[2]) begin
      pack = pack | ({thr_i, {(TOT-THR_W){1'b0}}} >> len);
      len  = len + CNT_W'(THR_W);
    end
  end

  assign take_o = fall_i && !busy_o && pending_i && out_en_i && (|en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      left_q  <= '0;
      busy_o  <= 1'b0;
      sdata_o <= 1'b0;
      frame_o <= 1'b0;
    end else if (take_o) begin
      shift_q <= pack;
      left_q  <= len;
      busy_o  <= 1'b1;
      sdata_o <= 1'b0;
      frame_o <= 1'b1;
    end else if (fall_i && busy_o) begin
      frame_o <= 1'b0;
      if (left_q == '0) begin
        busy_o  <= 1'b0;
        sdata_o <= 1'b0;
      end else begin
        sdata_o <= shift_q[TOT-1];
        shift_q <= shift_q << 1;
        left_q  <= left_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/smon_serial_port.sv
module smon_serial_port #(
  parameter int MAG_W = 20,
  parameter int PK_W  = 13,
  parameter int THR_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MAG_W-1:0] mag_i,
  input  logic [PK_W-1:0]  peak_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             result_valid_i,
  input  logic             mag_en_i,
  input  logic             peak_en_i,
  input  logic             thr_en_i,
  input  logic [1:0]       div_sel_i,
  input  logic             sleep_i,
  input  logic             out_en_i,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             frame_o
);
  logic             busy, pending, take, fall, run;
  logic [MAG_W-1:0] h_mag;
  logic [PK_W-1:0]  h_peak;
  logic [THR_W-1:0] h_thr;

  assign run = !sleep_i || busy || pending;

  smon_sclk_gen u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_sel_i(div_sel_i),
    .run_i(run), .sclk_o(sclk_o), .fall_o(fall)
  );

  smon_result_hold #(.MAG_W(MAG_W), .PK_W(PK_W), .THR_W(THR_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .mag_i(mag_i), .peak_i(peak_i),
    .thr_i(thr_i), .valid_i(result_valid_i), .take_i(take),
    .mag_o(h_mag), .peak_o(h_peak), .thr_o(h_thr), .pending_o(pending)
  );

  smon_frame_shift #(.MAG_W(MAG_W), .PK_W(PK_W), .THR_W(THR_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_i(fall), .pending_i(pending),
    .out_en_i(out_en_i), .en_i({thr_en_i, peak_en_i, mag_en_i}),
    .mag_i(h_mag), .peak_i(h_peak), .thr_i(h_thr),
    .take_o(take), .busy_o(busy), .sdata_o(sdata_o), .frame_o(frame_o)
  );
endmodule

// File: rtl/smon_serial_port_chk.sv
module smon_serial_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic sdata_o,
  input logic frame_o,
  input logic sleep_i,
  input logic out_en_i,
  input logic busy_i,
  input logic pending_i
);
  assert_data_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> $fell(sclk_o));

  assert_frame_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_o) |-> $fell(sclk_o));

  assert_frame_one_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sclk_o) && $past(frame_o) && $past(sclk_o)) |-> !frame_o);

  assert_data_low_in_marker_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> !sdata_o);

  assert_start_needs_enable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_o) |-> $past(out_en_i));

  assert_sleep_parks_clock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !busy_i && !pending_i) |=> !sclk_o);

  always_comb begin
    if (!rst_ni) begin
      assert_reset_low_R9: assert (!sclk_o && !sdata_o && !frame_o);
    end
  end
endmodule

bind smon_serial_port smon_serial_port_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sclk_o(sclk_o), .sdata_o(sdata_o),
  .frame_o(frame_o), .sleep_i(sleep_i), .out_en_i(out_en_i),
  .busy_i(busy), .pending_i(pending)
);

// File: tb/sim_smon_serial_port.sv
module sim_smon_serial_port;
  localparam int TOT = 46;

  typedef struct {
    logic [TOT-1:0] bits;
    int             len;
    string          tag;
  } frame_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] mag_i = '0;
  logic [12:0] peak_i = '0;
  logic [12:0] thr_i = '0;
  logic        result_valid_i = 1'b0;
  logic        mag_en_i = 1'b1, peak_en_i = 1'b1, thr_en_i = 1'b1;
  logic [1:0]  div_sel_i = 2'b01;
  logic        sleep_i = 1'b0;
  logic        out_en_i = 1'b1;
  logic        sclk_o, sdata_o, frame_o;

  int checks = 0, errors = 0, cycles = 0, frames_seen = 0;
  frame_t exp_q[$];
  bit     in_frame = 0;

  smon_serial_port u0 (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      finish_run();
    end
  end

  // driver: strobe one result set, push the expected frame (R1)
  task automatic send(input logic [19:0] m, input logic [12:0] p,
                      input logic [12:0] t, input string tag);
    frame_t f;
    f.bits = '0; f.len = 0; f.tag = tag;
    if (mag_en_i)  for (int i = 19; i >= 0; i--) begin f.bits[TOT-1-f.len] = m[i]; f.len++; end
    if (peak_en_i) for (int i = 12; i >= 0; i--) begin f.bits[TOT-1-f.len] = p[i]; f.len++; end
    if (thr_en_i)  for (int i = 12; i >= 0; i--) begin f.bits[TOT-1-f.len] = t[i]; f.len++; end
    exp_q.push_back(f);
    @(negedge clk_i);
    mag_i = m; peak_i = p; thr_i = t; result_valid_i = 1'b1;
    @(negedge clk_i);
    result_valid_i = 1'b0;
  endtask

  // monitor: sample on sclk rising, compare against queue
  logic           prev_sclk = 1'b0;
  frame_t         cur;
  logic [TOT-1:0] got;
  int             idx;
  always @(negedge clk_i) begin
    if (rst_ni && !prev_sclk && sclk_o) begin
      if (!in_frame) begin
        if (frame_o) begin
          frames_seen++;
          if (exp_q.size() == 0) begin
            check(0, "R5", "unexpected frame", 1, 0);
          end else begin
            cur = exp_q.pop_front();
            check(!sdata_o, "R2", "data during marker", sdata_o, 0);
            in_frame = 1; idx = 0; got = '0;
          end
        end else if (sdata_o && !sleep_i) begin
          check(0, "R7", "idle data", 1, 0);
        end
      end else begin
        if (frame_o) check(0, "R2", "marker wider than one period", 1, 0);
        got[TOT-1-idx] = sdata_o;
        idx++;
        if (idx == cur.len) begin
          check(got == cur.bits, "R1", cur.tag, got, cur.bits);
          in_frame = 0;
        end
      end
    end
    prev_sclk = sclk_o;
  end

  task automatic wait_done();
    do @(negedge clk_i); while (exp_q.size() != 0 || in_frame);
    repeat (20) @(negedge clk_i);
  endtask

  task automatic measure(input int exp, input string tag);
    int   c;
    logic p;
    c = 0;
    p = sclk_o;
    forever begin @(negedge clk_i); if (!p && sclk_o) break; p = sclk_o; end
    p = sclk_o;
    forever begin @(negedge clk_i); c++; if (!p && sclk_o) break; p = sclk_o; end
    check(c == exp, "R3", tag, c, exp);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    check(!sclk_o && !sdata_o && !frame_o, "R9", "reset outputs",
          {sclk_o, sdata_o, frame_o}, 0);
    rst_ni = 1'b1;

    // R3 divide codes
    measure(2, "div01"); measure(2, "div01");
    div_sel_i = 2'b10; measure(4, "div10"); measure(4, "div10");
    div_sel_i = 2'b11; measure(8, "div11"); measure(8, "div11");
    div_sel_i = 2'b00; measure(2, "div00"); measure(2, "div00");
    div_sel_i = 2'b01;

    // R1 all words, several patterns
    send(20'hA5C3E, 13'h1ABC, 13'h0F0F, "R1 all words");
    wait_done();
    send(20'hFFFFF, 13'h0000, 13'h1FFF, "R1 all words edge");
    wait_done();

    // R1 peak only, divide by 4
    div_sel_i = 2'b10; mag_en_i = 0; thr_en_i = 0;
    send(20'h12345, 13'h15A5, 13'h0777, "R1 peak only");
    wait_done();

    // R1 mag + thr, divide by 8
    div_sel_i = 2'b11; mag_en_i = 1; peak_en_i = 0; thr_en_i = 1;
    send(20'h80001, 13'h1111, 13'h1001, "R1 mag and thr");
    wait_done();
    div_sel_i = 2'b01; peak_en_i = 1;

    // R5 output enable gating
    out_en_i = 0;
    n = frames_seen;
    send(20'h0BEEF, 13'h0ACE, 13'h1234, "R5 held result");
    repeat (200) @(negedge clk_i);
    check(frames_seen == n, "R5", "frame while disabled", frames_seen, n);
    out_en_i = 1;
    wait_done();
    check(frames_seen == n + 1, "R5", "held result sent", frames_seen, n + 1);

    // R8 strobe during frame
    send(20'h33333, 13'h0CCC, 13'h1555, "R8 first frame");
    do @(negedge clk_i); while (!in_frame);
    repeat (10) @(negedge clk_i);
    send(20'h4C4C4, 13'h0101, 13'h1EEE, "R8 next frame");
    wait_done();
    check(exp_q.size() == 0, "R8", "queue drained", exp_q.size(), 0);

    // R7 free-running clock when not sleeping
    n = 0;
    begin
      logic p;
      p = sclk_o;
      for (int i = 0; i < 64; i++) begin
        @(negedge clk_i);
        if (!p && sclk_o) n++;
        p = sclk_o;
      end
    end
    check(n == 32, "R7", "rises in 64 cycles", n, 32);

    // R6 sleep parks clock
    sleep_i = 1;
    repeat (20) @(negedge clk_i);
    n = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk_i); if (sclk_o) n++; end
    check(n == 0, "R6", "sclk high while asleep", n, 0);
    send(20'h5A5A5, 13'h0A0A, 13'h1357, "R6 frame from sleep");
    wait_done();
    n = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk_i); if (sclk_o) n++; end
    check(n == 0, "R6", "sclk high after frame", n, 0);

    finish_run();
  end
endmodule